// File: doc/BRIEF.md
# Two-Way Doorbell Mailbox

This block is the register file that sits between a host processor and an embedded boot engine. It lets the two sides pass short messages to each other. The host owns four 64-bit command registers, and the engine owns four 64-bit response registers. Both sides can read all eight. Each direction has a doorbell register. Its bits tell the receiving side why it is being alerted, and any set bit raises a level interrupt toward that side.

A host sends a message in three steps. It writes the command registers in ascending order. It then sets the message-waiting bit through the doorbell's OR address. The engine reads the command and clears that bit through the AND address, which drops its interrupt. The engine replies the same way, through the response registers and the engine-to-host doorbell.

Both ports are simple synchronous register buses. A request is one cycle with an address, a write enable and write data. Read data appears on the port's data output on the clock edge that samples the read.

Top module: `mbx_top`

## Requirements
- R1: After reset, every command register, response register and doorbell is zero, both interrupts are low, and both read-data outputs are zero.
- R2: Host writes to word addresses 0..3 update the command registers, and either port reads them back at those addresses. Engine writes to 0..3 are ignored.
- R3: Engine writes to word addresses 4..7 update the response registers, and either port reads them back at those addresses. Host writes to 4..7 are ignored.
- R4: A read request (req high, we low) loads the port's read-data output on that clock edge. The output then holds its value through cycles without a read request.
- R5: A write to a doorbell's plain address replaces its contents. The host-to-engine doorbell is at 8 and the engine-to-host doorbell is at 12. Only the defined bits are stored: bit 0 host-to-engine (message waiting), bits 0..4 engine-to-host (response waiting, ack, passthrough, timer expiry, back from reset). Undefined bits read as zero.
- R6: A write to the OR address sets the written bits of a doorbell and leaves the other bits unchanged. The OR address is 9 for host-to-engine and 13 for engine-to-host.
- R7: A write to the AND address keeps only the written bits of a doorbell. The AND address is 10 for host-to-engine and 14 for engine-to-host. Writing (mask AND NOT bits) therefore clears the selected bits.
- R8: Each interrupt is the OR of its doorbell's bits, registered once. It rises one cycle after the doorbell becomes non-zero and falls one cycle after the doorbell is cleared. The host-to-engine doorbell drives the engine interrupt, and the engine-to-host doorbell drives the host interrupt.
- R9: When both ports access one doorbell in the same cycle, the plain write is applied first, then every AND mask, then every OR mask. A bit that is both cleared and set in that cycle therefore ends up set. If both ports issue a plain write, the host's value is the one that takes effect.
- R10: Reads of undefined word addresses (11, 15 and 16..31) return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access request |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | 5 | Host word address |
| host_wdata_i | input | 64 | Host write data |
| host_rdata_o | output | 64 | Host read data |
| eng_req_i | input | 1 | Engine access request |
| eng_we_i | input | 1 | Engine write enable |
| eng_addr_i | input | 5 | Engine word address |
| eng_wdata_i | input | 64 | Engine write data |
| eng_rdata_o | output | 64 | Engine read data |
| h2e_irq_o | output | 1 | Interrupt toward the engine |
| e2h_irq_o | output | 1 | Interrupt toward the host |

## Verification
The host can clear doorbell bits while the engine sets others in the same clock, so one doorbell can see an AND mask and an OR mask together. The bench drives both ports in a single cycle with opposing alias writes, and then with competing plain writes. It also checks the case where the host sets a bit at the same moment the engine wipes the doorbell. After each of these cycles the bench reads the doorbell back. It compares the value with the ordering in R9: plain write first, AND masks next, OR masks last, host ahead of engine.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    DB_NONE  = 2'd0,
    DB_WRITE = 2'd1,
    DB_OR    = 2'd2,
    DB_AND   = 2'd3
  } db_op_e;
endpackage

// File: rtl/mbx_bank.sv
module mbx_bank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 64
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_REGS-1:0]              we_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  q_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[g] <= '0;
      else if (we_i[g])   q_o[g] <= wdata_i;
    end
  end

  a_r2_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i == '0) |=> $stable(q_o));
  a_r2_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_i));
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  db_op_e       op_a_i,   // host side, wins plain-write ties
  input  logic [W-1:0] data_a_i,
  input  db_op_e       op_b_i,
  input  logic [W-1:0] data_b_i,
  output logic [W-1:0] q_o,
  output logic         irq_o
);
  logic [W-1:0] nxt;

  // order: plain write, then AND masks, then OR masks
  always_comb begin
    nxt = q_o;
    if (op_b_i == DB_WRITE) nxt = data_b_i;
    if (op_a_i == DB_WRITE) nxt = data_a_i;
    if (op_a_i == DB_AND)   nxt = nxt & data_a_i;
    if (op_b_i == DB_AND)   nxt = nxt & data_b_i;
    if (op_a_i == DB_OR)    nxt = nxt | data_a_i;
    if (op_b_i == DB_OR)    nxt = nxt | data_b_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      irq_o <= 1'b0;
    end else begin
      q_o   <= nxt;
      irq_o <= |q_o;
    end
  end

  a_r6_or_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_a_i == DB_OR && op_b_i == DB_NONE) |=> ((q_o & $past(data_a_i)) == $past(data_a_i)));
  a_r7_and_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_b_i == DB_AND && op_a_i == DB_NONE) |=> (q_o == ($past(q_o) & $past(data_b_i))));
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_a_i == DB_AND && op_b_i == DB_OR) |=> ((q_o & $past(data_b_i)) == $past(data_b_i)));
  a_r9_host_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_a_i == DB_WRITE && op_b_i == DB_WRITE) |=> (q_o == $past(data_a_i)));
  a_r8_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_a_i == DB_NONE && op_b_i == DB_NONE) |=> $stable(q_o));
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 5,
  parameter int H2E_W    = 1,
  parameter int E2H_W    = 5,
  parameter bit IS_HOST  = 1'b1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_i,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  cmd_q_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  rsp_q_i,
  input  logic [H2E_W-1:0]                 h2e_q_i,
  input  logic [E2H_W-1:0]                 e2h_q_i,
  output logic [NUM_REGS-1:0]              cmd_we_o,
  output logic [NUM_REGS-1:0]              rsp_we_o,
  output db_op_e                           h2e_op_o,
  output db_op_e                           e2h_op_o,
  output logic [DATA_W-1:0]                rdata_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] RSP_BASE = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] H2E_BASE = ADDR_W'(2 * NUM_REGS);
  localparam logic [ADDR_W-1:0] E2H_BASE = ADDR_W'(2 * NUM_REGS + 4);

  logic                wr, rd, in_cmd, in_rsp, undef;
  logic [ADDR_W-1:0]   h2e_off, e2h_off, rsp_off;
  logic [DATA_W-1:0]   rmux;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign in_cmd  = addr_i < RSP_BASE;
  assign in_rsp  = (addr_i >= RSP_BASE) && (addr_i < H2E_BASE);
  assign rsp_off = addr_i - RSP_BASE;
  assign h2e_off = addr_i - H2E_BASE;
  assign e2h_off = addr_i - E2H_BASE;

  function automatic db_op_e alias_op(input logic hit, input logic [ADDR_W-1:0] off);
    db_op_e op;
    op = DB_NONE;
    if (hit) begin
      case (off)
        ADDR_W'(0): op = DB_WRITE;
        ADDR_W'(1): op = DB_OR;
        ADDR_W'(2): op = DB_AND;
        default:    op = DB_NONE;
      endcase
    end
    return op;
  endfunction

  assign h2e_op_o = alias_op(wr && addr_i >= H2E_BASE && addr_i < E2H_BASE, h2e_off);
  assign e2h_op_o = alias_op(wr && addr_i >= E2H_BASE, e2h_off);

  always_comb begin
    cmd_we_o = '0;
    rsp_we_o = '0;
    if (wr && IS_HOST && in_cmd)  cmd_we_o[addr_i[IDX_W-1:0]] = 1'b1;
    if (wr && !IS_HOST && in_rsp) rsp_we_o[rsp_off[IDX_W-1:0]] = 1'b1;
  end

  always_comb begin
    undef = 1'b0;
    rmux  = '0;
    if (in_cmd)                                   rmux = cmd_q_i[addr_i[IDX_W-1:0]];
    else if (in_rsp)                              rmux = rsp_q_i[rsp_off[IDX_W-1:0]];
    else if (addr_i == H2E_BASE)                  rmux = {{(DATA_W-H2E_W){1'b0}}, h2e_q_i};
    else if (addr_i == E2H_BASE)                  rmux = {{(DATA_W-E2H_W){1'b0}}, e2h_q_i};
    else if (addr_i == H2E_BASE + ADDR_W'(1) || addr_i == H2E_BASE + ADDR_W'(2) ||
             addr_i == E2H_BASE + ADDR_W'(1) || addr_i == E2H_BASE + ADDR_W'(2))
                                                  rmux = '0;
    else                                          undef = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rmux;
  end

  a_r4_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
  a_r10_undef_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && undef) |=> (rdata_o == '0));
  a_r10_undef_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef |-> (cmd_we_o == '0 && rsp_we_o == '0 && h2e_op_o == DB_NONE && e2h_op_o == DB_NONE));
endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 5,
  parameter int H2E_W    = 1,
  parameter int E2H_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              eng_req_i,
  input  logic              eng_we_i,
  input  logic [ADDR_W-1:0] eng_addr_i,
  input  logic [DATA_W-1:0] eng_wdata_i,
  output logic [DATA_W-1:0] eng_rdata_o,
  output logic              h2e_irq_o,
  output logic              e2h_irq_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] cmd_q, rsp_q;
  logic [NUM_REGS-1:0] host_cmd_we, host_rsp_we, eng_cmd_we, eng_rsp_we;
  logic [NUM_REGS-1:0] cmd_we, rsp_we;
  logic [DATA_W-1:0]   cmd_wdata, rsp_wdata;
  logic [H2E_W-1:0]    h2e_q;
  logic [E2H_W-1:0]    e2h_q;
  db_op_e host_h2e_op, host_e2h_op, eng_h2e_op, eng_e2h_op;

  mbx_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
             .H2E_W(H2E_W), .E2H_W(E2H_W), .IS_HOST(1'b1)) u_host_port (
    .clk_i, .rst_ni,
    .req_i(host_req_i), .we_i(host_we_i), .addr_i(host_addr_i),
    .cmd_q_i(cmd_q), .rsp_q_i(rsp_q), .h2e_q_i(h2e_q), .e2h_q_i(e2h_q),
    .cmd_we_o(host_cmd_we), .rsp_we_o(host_rsp_we),
    .h2e_op_o(host_h2e_op), .e2h_op_o(host_e2h_op), .rdata_o(host_rdata_o));

  mbx_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
             .H2E_W(H2E_W), .E2H_W(E2H_W), .IS_HOST(1'b0)) u_eng_port (
    .clk_i, .rst_ni,
    .req_i(eng_req_i), .we_i(eng_we_i), .addr_i(eng_addr_i),
    .cmd_q_i(cmd_q), .rsp_q_i(rsp_q), .h2e_q_i(h2e_q), .e2h_q_i(e2h_q),
    .cmd_we_o(eng_cmd_we), .rsp_we_o(eng_rsp_we),
    .h2e_op_o(eng_h2e_op), .e2h_op_o(eng_e2h_op), .rdata_o(eng_rdata_o));

  // ownership is fixed in the port decode; one side's enables are always zero
  assign cmd_we    = host_cmd_we | eng_cmd_we;
  assign rsp_we    = host_rsp_we | eng_rsp_we;
  assign cmd_wdata = (|host_cmd_we) ? host_wdata_i : eng_wdata_i;
  assign rsp_wdata = (|eng_rsp_we)  ? eng_wdata_i  : host_wdata_i;

  mbx_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_cmd_bank (
    .clk_i, .rst_ni, .we_i(cmd_we), .wdata_i(cmd_wdata), .q_o(cmd_q));

  mbx_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rsp_bank (
    .clk_i, .rst_ni, .we_i(rsp_we), .wdata_i(rsp_wdata), .q_o(rsp_q));

  mbx_doorbell #(.W(H2E_W)) u_h2e_db (
    .clk_i, .rst_ni,
    .op_a_i(host_h2e_op), .data_a_i(host_wdata_i[H2E_W-1:0]),
    .op_b_i(eng_h2e_op),  .data_b_i(eng_wdata_i[H2E_W-1:0]),
    .q_o(h2e_q), .irq_o(h2e_irq_o));

  mbx_doorbell #(.W(E2H_W)) u_e2h_db (
    .clk_i, .rst_ni,
    .op_a_i(host_e2h_op), .data_a_i(host_wdata_i[E2H_W-1:0]),
    .op_b_i(eng_e2h_op),  .data_b_i(eng_wdata_i[E2H_W-1:0]),
    .q_o(e2h_q), .irq_o(e2h_irq_o));

  a_r2_engine_no_cmd_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_req_i && eng_we_i && eng_addr_i < ADDR_W'(NUM_REGS)) |=> $stable(cmd_q));
  a_r3_host_no_rsp_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && host_we_i && host_addr_i >= ADDR_W'(NUM_REGS) &&
     host_addr_i < ADDR_W'(2*NUM_REGS) && !(eng_req_i && eng_we_i)) |=> $stable(rsp_q));
  a_r8_irq_low_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h2e_q == '0 && $past(h2e_q) == '0) |=> !h2e_irq_o);
endmodule

// File: tb/tb_mbx_top.sv
`timescale 1ns/1ps
module tb_mbx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 0, host_we = 0, eng_req = 0, eng_we = 0;
  logic [4:0]  host_addr = '0, eng_addr = '0;
  logic [63:0] host_wdata = '0, eng_wdata = '0;
  logic [63:0] host_rdata, eng_rdata;
  logic        h2e_irq, e2h_irq;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  mbx_top dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .eng_req_i(eng_req), .eng_we_i(eng_we), .eng_addr_i(eng_addr),
    .eng_wdata_i(eng_wdata), .eng_rdata_o(eng_rdata),
    .h2e_irq_o(h2e_irq), .e2h_irq_o(e2h_irq));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, return at the next negedge
  task automatic host_wr(input logic [4:0] a, input logic [63:0] d);
    host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_req = 0; host_we = 0;
  endtask
  task automatic eng_wr(input logic [4:0] a, input logic [63:0] d);
    eng_req = 1; eng_we = 1; eng_addr = a; eng_wdata = d;
    @(negedge clk); eng_req = 0; eng_we = 0;
  endtask
  task automatic both_wr(input logic [4:0] ha, input logic [63:0] hd,
                         input logic [4:0] ea, input logic [63:0] ed);
    host_req = 1; host_we = 1; host_addr = ha; host_wdata = hd;
    eng_req = 1; eng_we = 1; eng_addr = ea; eng_wdata = ed;
    @(negedge clk); host_req = 0; host_we = 0; eng_req = 0; eng_we = 0;
  endtask
  task automatic host_rd(input logic [4:0] a, output logic [63:0] d);
    host_req = 1; host_we = 0; host_addr = a;
    @(negedge clk); host_req = 0; d = host_rdata;
  endtask
  task automatic eng_rd(input logic [4:0] a, output logic [63:0] d);
    eng_req = 1; eng_we = 0; eng_addr = a;
    @(negedge clk); eng_req = 0; d = eng_rdata;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    check("R1 host_rdata", host_rdata, '0);
    check("R1 eng_rdata", eng_rdata, '0);
    check("R1 h2e_irq", 64'(h2e_irq), 0);
    check("R1 e2h_irq", 64'(e2h_irq), 0);
    for (int i = 0; i < 8; i++) begin
      host_rd(5'(i), d); check("R1 data reg", d, '0);
    end
    host_rd(8, d);  check("R1 h2e db", d, '0);
    host_rd(12, d); check("R1 e2h db", d, '0);
  endtask

  task automatic t_cmd;
    logic [63:0] d;
    for (int i = 0; i < 4; i++) host_wr(5'(i), 64'hC0DE_0000_0000_0000 + 64'(i * 17));
    for (int i = 0; i < 4; i++) begin
      eng_rd(5'(i), d); check("R2 engine reads cmd", d, 64'hC0DE_0000_0000_0000 + 64'(i * 17));
    end
    eng_wr(1, 64'hBAD);
    host_rd(1, d); check("R2 engine write to cmd ignored", d, 64'hC0DE_0000_0000_0011);
  endtask

  task automatic t_rsp;
    logic [63:0] d;
    for (int i = 0; i < 4; i++) eng_wr(5'(4 + i), 64'h5A5A_0000_0000_1000 + 64'(i));
    for (int i = 0; i < 4; i++) begin
      host_rd(5'(4 + i), d); check("R3 host reads rsp", d, 64'h5A5A_0000_0000_1000 + 64'(i));
    end
    host_wr(6, 64'hBAD);
    eng_rd(6, d); check("R3 host write to rsp ignored", d, 64'h5A5A_0000_0000_1002);
  endtask

  task automatic t_hold;
    host_rd(0, dummy);
    host_wr(2, 64'h1234);
    @(negedge clk);
    check("R4 rdata holds without read", host_rdata, 64'hC0DE_0000_0000_0000);
  endtask
  logic [63:0] dummy;

  task automatic t_h2e;
    logic [63:0] d;
    host_wr(9, 64'hFF);
    check("R8 irq not yet", 64'(h2e_irq), 0);
    @(negedge clk);
    check("R8 h2e irq rises one cycle later", 64'(h2e_irq), 1);
    eng_rd(8, d); check("R6 OR sets message waiting, undefined bits dropped", d, 64'h1);
    eng_wr(10, 64'h0);
    check("R8 irq still high", 64'(h2e_irq), 1);
    @(negedge clk);
    check("R8 h2e irq falls after clear", 64'(h2e_irq), 0);
    eng_rd(8, d); check("R7 AND clears", d, 64'h0);
  endtask

  task automatic t_e2h;
    logic [63:0] d;
    eng_wr(12, 64'hFFFF);
    host_rd(12, d); check("R5 plain write keeps defined bits", d, 64'h1F);
    check("R8 e2h irq high", 64'(e2h_irq), 1);
    host_wr(14, 64'h1F & ~64'h2);
    host_rd(12, d); check("R7 AND clears ack only", d, 64'h1D);
    eng_wr(13, 64'h2);
    host_rd(12, d); check("R6 OR sets ack", d, 64'h1F);
    host_wr(12, 64'h0);
    @(negedge clk);
    check("R8 e2h irq low after clear", 64'(e2h_irq), 0);
  endtask

  task automatic t_same_cycle;
    logic [63:0] d;
    eng_wr(12, 64'h5);
    both_wr(14, 64'h0, 13, 64'h8);
    host_rd(12, d); check("R9 host AND with engine OR", d, 64'h8);
    both_wr(13, 64'h1, 14, 64'h0);
    host_rd(12, d); check("R9 OR after AND regardless of port", d, 64'h1);
    both_wr(14, 64'h1E, 13, 64'h1);
    host_rd(12, d); check("R9 clear and set same bit -> set", d, 64'h1);
    both_wr(12, 64'h3, 12, 64'h4);
    host_rd(12, d); check("R9 host plain write wins", d, 64'h3);
    both_wr(9, 64'h1, 8, 64'h0);
    eng_rd(8, d); check("R9 write then OR on h2e", d, 64'h1);
  endtask

  task automatic t_undef;
    logic [63:0] d;
    host_wr(11, 64'hFFFF_FFFF);
    host_wr(15, 64'hFFFF_FFFF);
    eng_wr(20, 64'hFFFF_FFFF);
    host_rd(11, d); check("R10 read 11 zero", d, 0);
    eng_rd(15, d);  check("R10 read 15 zero", d, 0);
    host_rd(20, d); check("R10 read 20 zero", d, 0);
    host_rd(12, d); check("R10 e2h unchanged", d, 64'h3);
    eng_rd(8, d);   check("R10 h2e unchanged", d, 64'h1);
    host_rd(3, d);  check("R10 cmd unchanged", d, 64'hC0DE_0000_0000_0033);
    host_rd(7, d);  check("R10 rsp unchanged", d, 64'h5A5A_0000_0000_1003);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd();
    t_rsp();
    t_hold();
    t_h2e();
    t_e2h();
    t_same_cycle();
    t_undef();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule